// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a double-data-rate SDRAM out of power-up. After reset it holds the command bus idle for a wait whose length in clocks comes from the clock frequency and the wait time. It then issues a fixed script of precharge-all, register-load and auto-refresh commands. Every gap between commands is filled with NOPs, and each gap lasts a parameterized spacing. After the last register load it keeps user traffic blocked for a further hold-off period. It then raises an init-done flag, which the normal read/write path waits for before it may issue commands.

The command is driven as a 2-bit code together with the bank-select and address lines. A register load places the register select on the bank lines and the register value on the address lines. All delays are parameters, so a simulation can use short waits. A synchronous reset at any point restarts the script from the beginning of the idle wait.

Top module: `sdram_init_seq`

## Requirements
- R1: In the first cycle after reset, mem_cmd is NOP (code 0), mem_ba and mem_addr are zero, init_done is 0 and busy is 1.
- R2: After reset, exactly IDLE_CYC = CLK_MHZ*IDLE_US cycles of NOP are driven. The first non-NOP command appears in cycle IDLE_CYC, counted from cycle 0 after reset, and it is precharge-all (code 1).
- R3: Exactly seven non-NOP commands are issued, in this order: precharge-all, load (extended), load (mode), precharge-all, auto-refresh (code 3), auto-refresh, load (mode). A load uses code 2.
- R4: Exactly T_RP NOP cycles follow each precharge-all. Exactly T_MRD follow each of the first two loads. Exactly T_RFC follow each auto-refresh.
- R5: The extended load drives mem_ba=1 and mem_addr=EXT_VAL. The first mode load drives mem_ba=0 and mem_addr=MODE_INIT_VAL. The final mode load drives mem_ba=0 and mem_addr=MODE_RUN_VAL.
- R6: Precharge-all drives mem_addr with only bit AP_BIT set, and mem_ba=0. Auto-refresh and NOP cycles drive mem_ba and mem_addr to zero.
- R7: Exactly HOLD_CYC NOP cycles follow the final load. init_done then rises in the next cycle. busy is always the complement of init_done.
- R8: Once init_done is high, it stays high and mem_cmd stays NOP until the next reset.
- R9: Reset asserted at any point forces NOP and init_done low in the cycle after the reset edge. Releasing reset replays the whole script from the start of the idle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_cmd | output | 2 | Command code: 0 NOP, 1 precharge-all, 2 register load, 3 auto-refresh |
| mem_ba | output | BA_W | Bank-select lines (register select during a load) |
| mem_addr | output | ADDR_W | Address lines (register value during a load) |
| busy | output | 1 | High while the script is running |
| init_done | output | 1 | High once the script and hold-off have completed |

## Verification
A step counter that advances wrongly shows up at the ports as a command in the wrong order. It also shows up as a missing or extra refresh, or a command one cycle early or late. The bench sees this at the very next non-NOP command, because it compares every command cycle against a timeline computed from the parameters. A wrong decode of the step shows up as wrong bank or address values in that same cycle. A hold-off counter that is off by one moves the rise of init_done by a cycle, and this is seen at the single cycle where the flag is checked. A reset that fails to clear state shows within one cycle of the reset edge.

// File: rtl/sdram_init_pkg.sv
// Shared definitions for the SDRAM power-up sequencer.
// Assumes a 2-bit command code understood by the command-bus driver.
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_PREA  = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_AREF  = 2'd3
    } mem_cmd_t;

    // Script steps in issue order; ST_DONE is terminal.
    typedef enum logic [3:0] {
        ST_WAIT = 4'd0,
        ST_PRE1 = 4'd1,
        ST_LDX  = 4'd2,
        ST_LDM  = 4'd3,
        ST_PRE2 = 4'd4,
        ST_REF1 = 4'd5,
        ST_REF2 = 4'd6,
        ST_LDR  = 4'd7,
        ST_HOLD = 4'd8,
        ST_DONE = 4'd9
    } step_t;

endpackage

// File: rtl/sdram_init_timer.sv
// Step-length counter. Counts the cycles spent in the current step.
// It flags the first cycle (command slot) and the last cycle (advance).
// Assumes len >= 1 and len stays constant while a step runs.
module sdram_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] len,
    output logic             first,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Count up within a step, wrap to zero on the step's last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Decode the slot position from the count.
    always_comb begin
        first = (cnt == '0);
        last  = (cnt == len - 1'b1);
    end
endmodule

// File: rtl/sdram_init_step.sv
// Step register for the power-up script. Advances one step each time the
// timer reports the last cycle of a step. It stops in ST_DONE.
// Assumes the timer's last flag is valid every cycle.
module sdram_init_step
    import sdram_init_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  last,
    output step_t step
);
    // Move to the next script step at the end of the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= ST_WAIT;
        else if (last && step != ST_DONE)
            step <= step_t'(step + 4'd1);
    end
endmodule

// File: rtl/sdram_init_decode.sv
// Command decoder. Turns the current step and the command-slot flag into
// the command code, bank lines and address lines. Outside the command slot,
// and in the wait, hold and done steps, it drives NOP with zero bank and
// address. Assumes AP_BIT < ADDR_W.
module sdram_init_decode
    import sdram_init_pkg::*;
#(
    parameter int                ADDR_W        = 13,
    parameter int                BA_W          = 2,
    parameter int                AP_BIT        = 10,
    parameter logic [ADDR_W-1:0] EXT_VAL       = '0,
    parameter logic [ADDR_W-1:0] MODE_INIT_VAL = '0,
    parameter logic [ADDR_W-1:0] MODE_RUN_VAL  = '0
) (
    input  step_t             step,
    input  logic              first,
    output mem_cmd_t          cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] PREA_ADDR = ADDR_W'(1) << AP_BIT;
    localparam logic [BA_W-1:0]   SEL_MODE  = BA_W'(0);
    localparam logic [BA_W-1:0]   SEL_EXT   = BA_W'(1);

    // Map the step to its command and bus values during the command slot.
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        if (first) begin
            unique case (step)
                ST_PRE1, ST_PRE2: begin
                    cmd  = CMD_PREA;
                    addr = PREA_ADDR;
                end
                ST_LDX: begin
                    cmd  = CMD_LOAD;
                    ba   = SEL_EXT;
                    addr = EXT_VAL;
                end
                ST_LDM: begin
                    cmd  = CMD_LOAD;
                    ba   = SEL_MODE;
                    addr = MODE_INIT_VAL;
                end
                ST_LDR: begin
                    cmd  = CMD_LOAD;
                    ba   = SEL_MODE;
                    addr = MODE_RUN_VAL;
                end
                ST_REF1, ST_REF2: cmd = CMD_AREF;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up initialization sequencer (top).
// After reset it idles for CLK_MHZ*IDLE_US cycles and then runs a fixed script.
// Every command is followed by its spacing in NOPs. A HOLD_CYC hold-off
// follows the final register load, and then init_done is raised.
// Assumes the spacing parameters are >= 1 and HOLD_CYC >= T_MRD.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int                ADDR_W        = 13,
    parameter int                BA_W          = 2,
    parameter int                AP_BIT        = 10,
    parameter int                CLK_MHZ       = 100,
    parameter int                IDLE_US       = 200,
    parameter int                T_RP          = 3,
    parameter int                T_MRD         = 2,
    parameter int                T_RFC         = 8,
    parameter int                HOLD_CYC      = 200,
    parameter logic [ADDR_W-1:0] EXT_VAL       = '0,
    parameter logic [ADDR_W-1:0] MODE_INIT_VAL = 13'h0162,
    parameter logic [ADDR_W-1:0] MODE_RUN_VAL  = 13'h0062
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [1:0]        mem_cmd,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              init_done
);
    localparam int IDLE_CYC = CLK_MHZ * IDLE_US;
    localparam int GAP_A    = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int GAP_MAX  = (GAP_A > T_RFC) ? GAP_A : T_RFC;
    localparam int LEN_A    = (IDLE_CYC > HOLD_CYC) ? IDLE_CYC : HOLD_CYC;
    localparam int MAX_LEN  = (LEN_A > GAP_MAX + 1) ? LEN_A : GAP_MAX + 1;
    localparam int CNT_W    = $clog2(MAX_LEN + 1);

    step_t            step;
    logic             first;
    logic             last;
    logic [CNT_W-1:0] len;
    mem_cmd_t         cmd;

    // Length in cycles of the current step: command slot plus its NOP spacing.
    always_comb begin
        unique case (step)
            ST_WAIT:          len = CNT_W'(IDLE_CYC);
            ST_PRE1, ST_PRE2: len = CNT_W'(T_RP + 1);
            ST_LDX, ST_LDM:   len = CNT_W'(T_MRD + 1);
            ST_REF1, ST_REF2: len = CNT_W'(T_RFC + 1);
            ST_HOLD:          len = CNT_W'(HOLD_CYC);
            default:          len = CNT_W'(1);
        endcase
    end

    sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .len   (len),
        .first (first),
        .last  (last)
    );

    sdram_init_step u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .last  (last),
        .step  (step)
    );

    sdram_init_decode #(
        .ADDR_W        (ADDR_W),
        .BA_W          (BA_W),
        .AP_BIT        (AP_BIT),
        .EXT_VAL       (EXT_VAL),
        .MODE_INIT_VAL (MODE_INIT_VAL),
        .MODE_RUN_VAL  (MODE_RUN_VAL)
    ) u_decode (
        .step  (step),
        .first (first),
        .cmd   (cmd),
        .ba    (mem_ba),
        .addr  (mem_addr)
    );

    // Drive the command port and the status flags from the step register.
    always_comb begin
        mem_cmd   = cmd;
        init_done = (step == ST_DONE);
        busy      = (step != ST_DONE);
    end
endmodule

// File: rtl/sdram_init_chk.sv
// Protocol checker for sdram_init_seq, attached by bind.
// It checks port-level rules of the power-up script.
module sdram_init_chk #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mem_cmd,
    input logic [BA_W-1:0]   mem_ba,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              init_done
);
    localparam logic [1:0] C_NOP  = 2'd0;
    localparam logic [1:0] C_PREA = 2'd1;
    localparam logic [1:0] C_LOAD = 2'd2;
    localparam logic [1:0] C_AREF = 2'd3;

    logic [2:0] n_ref;
    logic [2:0] n_load;

    // Count refreshes and register loads issued since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_ref  <= '0;
            n_load <= '0;
        end else begin
            if (mem_cmd == C_AREF && n_ref != 3'd7)  n_ref  <= n_ref + 1'b1;
            if (mem_cmd == C_LOAD && n_load != 3'd7) n_load <= n_load + 1'b1;
        end
    end

    a_r3_two_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_AREF) |-> (n_ref < 3'd2));

    a_r3_three_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_LOAD) |-> (n_load < 3'd3));

    a_r4_nop_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd != C_NOP) |=> (mem_cmd == C_NOP));

    a_r5_load_select: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_LOAD) |-> (mem_ba <= BA_W'(1)));

    a_r6_prea_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_PREA) |-> (mem_addr == (ADDR_W'(1) << AP_BIT) && mem_ba == '0));

    a_r6_aref_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_AREF) |-> (mem_addr == '0 && mem_ba == '0));

    a_r7_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
        busy != init_done);

    a_r7_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (n_load == 3'd3 && n_ref == 3'd2));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (mem_cmd == C_NOP));
endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .AP_BIT (AP_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cmd   (mem_cmd),
    .mem_ba    (mem_ba),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .init_done (init_done)
);

// File: tb/sdram_init_seq_bench.sv
// Directed bench for sdram_init_seq: each task runs one scenario and checks it.
module sdram_init_seq_bench;
    localparam int ADDR_W   = 13;
    localparam int BA_W     = 2;
    localparam int AP_BIT   = 10;
    localparam int CLK_MHZ  = 2;
    localparam int IDLE_US  = 10;
    localparam int T_RP     = 2;
    localparam int T_MRD    = 2;
    localparam int T_RFC    = 5;
    localparam int HOLD_CYC = 200;
    localparam logic [ADDR_W-1:0] EXT_V  = 13'h0041;
    localparam logic [ADDR_W-1:0] MINI_V = 13'h0133;
    localparam logic [ADDR_W-1:0] MRUN_V = 13'h0033;
    localparam int IDLE_CYC = CLK_MHZ * IDLE_US;

    // Command codes as stated in the requirements.
    localparam logic [1:0] K_NOP  = 2'd0;
    localparam logic [1:0] K_PREA = 2'd1;
    localparam logic [1:0] K_LOAD = 2'd2;
    localparam logic [1:0] K_AREF = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mem_cmd;
    logic [BA_W-1:0]   mem_ba;
    logic [ADDR_W-1:0] mem_addr;
    logic              busy;
    logic              init_done;

    int n_tests = 0;
    int n_fail  = 0;

    // Expected timeline of the seven commands.
    int                exp_cyc [7];
    logic [1:0]        exp_cmd [7];
    logic [BA_W-1:0]   exp_ba  [7];
    logic [ADDR_W-1:0] exp_addr[7];
    int                done_cyc;

    always #5 clk = ~clk;

    sdram_init_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT),
        .CLK_MHZ(CLK_MHZ), .IDLE_US(IDLE_US),
        .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .HOLD_CYC(HOLD_CYC),
        .EXT_VAL(EXT_V), .MODE_INIT_VAL(MINI_V), .MODE_RUN_VAL(MRUN_V)
    ) u_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .mem_cmd(mem_cmd), .mem_ba(mem_ba),
        .mem_addr(mem_addr), .busy(busy), .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Build the expected command timeline from the parameters.
    task automatic build_expect();
        int gap [7];
        gap = '{T_RP, T_MRD, T_MRD, T_RP, T_RFC, T_RFC, 0};
        exp_cmd  = '{K_PREA, K_LOAD, K_LOAD, K_PREA, K_AREF, K_AREF, K_LOAD};
        exp_ba   = '{0, 1, 0, 0, 0, 0, 0};
        exp_addr = '{ADDR_W'(1) << AP_BIT, EXT_V, MINI_V, ADDR_W'(1) << AP_BIT, 0, 0, MRUN_V};
        exp_cyc[0] = IDLE_CYC;
        for (int i = 1; i < 7; i++) exp_cyc[i] = exp_cyc[i-1] + 1 + gap[i-1];
        done_cyc = exp_cyc[6] + 1 + HOLD_CYC;
    endtask

    // Hold reset for a few cycles and release on a falling edge (cycle 0).
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: outputs in the first cycle after reset.
    task automatic t_reset_state();
        do_reset();
        check(mem_cmd == K_NOP, "R1", "cmd after reset", mem_cmd, K_NOP);
        check(mem_ba == 0 && mem_addr == 0, "R1", "bus after reset", mem_addr, 0);
        check(init_done == 1'b0 && busy == 1'b1, "R1", "flags after reset", init_done, 0);
    endtask

    // R2..R7: walk the whole script from cycle 0 and compare every command.
    task automatic t_full_script(input string tag);
        int seen = 0;
        int nop_bad = 0;
        int flag_bad = 0;
        for (int c = 0; c <= done_cyc + 2; c++) begin
            if (c > 0) @(negedge clk);
            if (mem_cmd != K_NOP) begin
                if (seen < 7) begin
                    check(c == exp_cyc[seen], (seen == 0) ? "R2" : "R4",
                          $sformatf("%s cycle of cmd %0d", tag, seen), c, exp_cyc[seen]);
                    check(mem_cmd == exp_cmd[seen], "R3",
                          $sformatf("%s code of cmd %0d", tag, seen), mem_cmd, exp_cmd[seen]);
                    check(mem_ba == exp_ba[seen] && mem_addr == exp_addr[seen],
                          (exp_cmd[seen] == K_LOAD) ? "R5" : "R6",
                          $sformatf("%s addr of cmd %0d", tag, seen), mem_addr, exp_addr[seen]);
                end
                seen++;
            end else if (mem_ba != 0 || mem_addr != 0) begin
                nop_bad++;
            end
            if ((c >= done_cyc) != init_done || busy == init_done) flag_bad++;
        end
        check(seen == 7, "R3", {tag, " command count"}, seen, 7);
        check(nop_bad == 0, "R6", {tag, " NOP cycles with nonzero bus"}, nop_bad, 0);
        check(flag_bad == 0, "R7", {tag, " cycles with wrong init_done/busy"}, flag_bad, 0);
    endtask

    // R8: after completion the bus stays quiet and done stays high.
    task automatic t_after_done();
        int bad = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (mem_cmd != K_NOP || !init_done) bad++;
        end
        check(bad == 0, "R8", "cycles disturbing done state", bad, 0);
    endtask

    // R9: reset while done, and reset in mid-script, both restart cleanly.
    task automatic t_midway_reset();
        rst_n = 1'b0;
        @(negedge clk);
        check(init_done == 1'b0 && mem_cmd == K_NOP, "R9", "done cleared by reset", init_done, 0);
        rst_n = 1'b1;
        repeat (exp_cyc[2] + 1) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(mem_cmd == K_NOP && busy == 1'b1, "R9", "mid-script reset quiets bus", mem_cmd, K_NOP);
        rst_n = 1'b1;
        t_full_script("R9 replay");
    endtask

    initial begin
        build_expect();
        t_reset_state();
        t_full_script("first run");
        t_after_done();
        t_midway_reset();
        t_after_done();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule